// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase Timer

This timer provides the shared counting base for a group of PWM channels. It takes one of two single-cycle tick inputs: a fast tick derived from the system clock or a slow reference tick. It divides the chosen tick by a fixed-point ratio that has a 10-bit integer part and an 8-bit fraction. Each divided tick advances a free-running counter. The counter wraps at a power of two that a resolution field sets at run time. Channel comparators downstream read the live count. An interrupt controller takes the wrap pulse.

The fraction is spread across periods by an 8-bit accumulator. Each divided period lasts the integer number of source ticks, and it lasts one tick more whenever adding the fraction into the accumulator produces a carry. Writes to the ratio and the resolution pass through a shadow stage. An update request captures them and raises a pending flag. The new values take effect at the next counter wrap, or at once while the counter is held clear. A PWM period is therefore never cut short. The pause input freezes the count and the clear input zeroes it.

Top module: `pwm_timebase`

## Requirements
- R1: After the synchronous reset, `cnt_o` is 0, `wrap_o` is 0 and `upd_pending_o` is 0. The active ratio is 1.0 and the active resolution is 8, so with a fast tick every cycle the wrap pulses are 256 cycles apart.
- R2: `src_sel_i` = 1 counts `fast_tick_i` and `src_sel_i` = 0 counts `ref_tick_i`. The tick that is not selected has no effect.
- R3: `ratio_i` is encoded as {integer[17:8], fraction[7:0]}. With a zero fraction, one divided tick occurs every `integer` source ticks. An integer part of 0 behaves as 1.
- R4: With fraction F, exactly F out of any 256 consecutive divided periods are one source tick longer. At resolution r, the wrap interval in source ticks is therefore 2^r·integer + F·2^r/256 whenever that product is whole.
- R5: The counter steps by one per divided tick through 0 … 2^res−1 and then returns to 0. With resolution 0 it stays at 0 and wraps on every divided tick.
- R6: A resolution above 20 acts as 20. The counter then runs through the full 20-bit range without wrapping early.
- R7: While `pause_i` is high and `clear_i` is low, the counter and the divider hold their state. On release, counting resumes without losing the tick that was in flight.
- R8: While `clear_i` is high, the counter is 0 and the divider restarts. Clear overrides pause. A pending update is applied at once while clear is high.
- R9: `wrap_o` is high for one cycle per wrap, in the cycle where `cnt_o` first shows 0 after showing the top value.
- R10: A high `upd_load_i` captures `ratio_i` and `res_i` into the shadow stage. `upd_pending_o` reads 1 from the next cycle until the update is applied. The update is applied at the next wrap, and the count finishes its old range first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick_i | input | 1 | Fast source tick, one cycle per tick |
| ref_tick_i | input | 1 | Slow reference tick, one cycle per tick |
| src_sel_i | input | 1 | Source select: 1 fast, 0 reference |
| pause_i | input | 1 | Freeze counter and divider |
| clear_i | input | 1 | Hold counter at 0 and restart the divider |
| upd_load_i | input | 1 | Capture ratio and resolution into the shadow stage |
| ratio_i | input | 18 | Divide ratio, 10.8 fixed point |
| res_i | input | 5 | Counter resolution (log2 of the range) |
| cnt_o | output | 20 | Live counter value |
| wrap_o | output | 1 | One-cycle wrap pulse |
| upd_pending_o | output | 1 | Shadow update waiting for a wrap |

## Verification
A fault in the fraction accumulator causes no immediate error. It shows up as a wrap interval that is a few cycles off after one full counter range, which is why the intervals are measured over whole wraps at several fractions. A wrong resolution or a wrong top compare shows on `cnt_o` within one range: the counter either goes past the expected top or wraps early. This is why the clamp case runs tens of thousands of cycles. A broken shadow path shows within one wrap, either as `upd_pending_o` failing to fall or as a range cut short in the middle of a period.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int unsigned TB_CNT_W  = 20;
  localparam int unsigned TB_INT_W  = 10;
  localparam int unsigned TB_FRAC_W = 8;
  localparam int unsigned TB_RES_W  = 5;
  localparam int unsigned TB_RST_RES = 8;

  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_FAST = 1'b1
  } tb_src_e;
endpackage

// File: rtl/pwm_tb_shadow.sv
module pwm_tb_shadow #(
  parameter int unsigned RATIO_W   = 18,
  parameter int unsigned RES_W     = 5,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned RST_RATIO = 256,
  parameter int unsigned RST_RES   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               apply_i,
  output logic [RATIO_W-1:0] act_ratio_o,
  output logic [RES_W-1:0]   act_res_o,
  output logic               pending_o
);
  localparam logic [RES_W-1:0] RES_MAX = RES_W'(CNT_W);

  logic [RATIO_W-1:0] sh_ratio_q, nxt_ratio;
  logic [RES_W-1:0]   sh_res_q, nxt_res, res_clamped;
  logic               pend_q, nxt_pend;

  // Out-of-range resolutions are folded to the widest counter
  assign res_clamped = (res_i > RES_MAX) ? RES_MAX : res_i;
  assign nxt_ratio   = load_i ? ratio_i : sh_ratio_q;
  assign nxt_res     = load_i ? res_clamped : sh_res_q;
  assign nxt_pend    = load_i | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ratio_q  <= RATIO_W'(RST_RATIO);
      sh_res_q    <= RES_W'(RST_RES);
      pend_q      <= 1'b0;
      act_ratio_o <= RATIO_W'(RST_RATIO);
      act_res_o   <= RES_W'(RST_RES);
    end else begin
      sh_ratio_q <= nxt_ratio;
      sh_res_q   <= nxt_res;
      if (apply_i && nxt_pend) begin
        act_ratio_o <= nxt_ratio;
        act_res_o   <= nxt_res;
        pend_q      <= 1'b0;
      end else begin
        pend_q <= nxt_pend;
      end
    end
  end

  assign pending_o = pend_q;

  assert_res_clamped_R6: assert property (@(posedge clk) disable iff (rst)
    act_res_o <= RES_MAX);

  assert_pending_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (apply_i && (pend_q || load_i)) |=> !pend_q);

  assert_pending_on_load_R10: assert property (@(posedge clk) disable iff (rst)
    (load_i && !apply_i) |=> pend_q);
endmodule

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int unsigned INT_W  = 10,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear_i,
  input  logic                    pause_i,
  input  logic                    src_tick_i,
  input  logic [INT_W+FRAC_W-1:0] ratio_i,
  output logic                    div_tick_o
);
  localparam int unsigned RATIO_W = INT_W + FRAC_W;
  localparam int unsigned PC_W    = INT_W + 1;

  logic [INT_W-1:0]  int_part, int_eff;
  logic [FRAC_W-1:0] frac_part;
  logic [PC_W-1:0]   pc_q, period_len, pc_inc;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              extra_q, div_q, last_tick;

  assign int_part   = ratio_i[RATIO_W-1:FRAC_W];
  assign frac_part  = ratio_i[FRAC_W-1:0];
  assign int_eff    = (int_part == '0) ? INT_W'(1) : int_part;
  assign period_len = {1'b0, int_eff} + PC_W'(extra_q);
  assign pc_inc     = pc_q + PC_W'(1);
  // >= keeps a mid-period ratio change from running past the new length
  assign last_tick  = (pc_inc >= period_len);
  assign acc_sum    = {1'b0, acc_q} + {1'b0, frac_part};

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pc_q    <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
      div_q   <= 1'b0;
    end else if (pause_i) begin
      // hold everything, including a tick already issued
      pc_q    <= pc_q;
    end else if (src_tick_i) begin
      if (last_tick) begin
        pc_q    <= '0;
        acc_q   <= acc_sum[FRAC_W-1:0];
        extra_q <= acc_sum[FRAC_W];
        div_q   <= 1'b1;
      end else begin
        pc_q  <= pc_inc;
        div_q <= 1'b0;
      end
    end else begin
      div_q <= 1'b0;
    end
  end

  assign div_tick_o = div_q;

  assert_tick_from_source_R2: assert property (@(posedge clk) disable iff (rst || clear_i)
    (div_q && !$past(pause_i) && !$past(clear_i)) |-> $past(src_tick_i));
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned RES_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             pause_i,
  input  logic             step_i,
  input  logic [RES_W-1:0] res_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_evt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, top;
  logic             wrap_q, advance;

  assign top        = ~({CNT_W{1'b1}} << res_i);
  assign advance    = step_i && !pause_i && !clear_i;
  assign wrap_evt_o = advance && (cnt_q == top);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_evt_o;
      if (wrap_evt_o)   cnt_q <= '0;
      else if (advance) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= top);

  assert_pause_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (pause_i && !clear_i) |=> (cnt_q == $past(cnt_q)));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0 && !wrap_q));

  assert_wrap_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int unsigned CNT_W   = TB_CNT_W,
  parameter int unsigned INT_W   = TB_INT_W,
  parameter int unsigned FRAC_W  = TB_FRAC_W,
  parameter int unsigned RES_W   = TB_RES_W,
  parameter int unsigned RST_RES = TB_RST_RES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fast_tick_i,
  input  logic                    ref_tick_i,
  input  logic                    src_sel_i,
  input  logic                    pause_i,
  input  logic                    clear_i,
  input  logic                    upd_load_i,
  input  logic [INT_W+FRAC_W-1:0] ratio_i,
  input  logic [RES_W-1:0]        res_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    wrap_o,
  output logic                    upd_pending_o
);
  localparam int unsigned RATIO_W   = INT_W + FRAC_W;
  localparam int unsigned RST_RATIO = 1 << FRAC_W;

  tb_src_e            src_sel;
  logic               src_tick, div_tick, wrap_evt, apply;
  logic [RATIO_W-1:0] act_ratio;
  logic [RES_W-1:0]   act_res;

  assign src_sel  = tb_src_e'(src_sel_i);
  assign src_tick = (src_sel == SRC_FAST) ? fast_tick_i : ref_tick_i;
  assign apply    = wrap_evt | clear_i;

  pwm_tb_shadow #(
    .RATIO_W(RATIO_W), .RES_W(RES_W), .CNT_W(CNT_W),
    .RST_RATIO(RST_RATIO), .RST_RES(RST_RES)
  ) u_shadow (
    .clk(clk), .rst(rst), .load_i(upd_load_i), .ratio_i(ratio_i),
    .res_i(res_i), .apply_i(apply), .act_ratio_o(act_ratio),
    .act_res_o(act_res), .pending_o(upd_pending_o)
  );

  pwm_tb_prescaler #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_presc (
    .clk(clk), .rst(rst), .clear_i(clear_i), .pause_i(pause_i),
    .src_tick_i(src_tick), .ratio_i(act_ratio), .div_tick_o(div_tick)
  );

  pwm_tb_counter #(.CNT_W(CNT_W), .RES_W(RES_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(clear_i), .pause_i(pause_i),
    .step_i(div_tick), .res_i(act_res), .cnt_o(cnt_o),
    .wrap_evt_o(wrap_evt), .wrap_o(wrap_o)
  );
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_tick = 1'b1, ref_tick = 1'b0, src_sel = 1'b1;
  logic        pause = 1'b0, clear = 1'b0, load = 1'b0;
  logic [17:0] ratio = 18'h00100;
  logic [4:0]  res = 5'd8;
  logic [19:0] cnt;
  logic        wrap, pending;
  int          n_chk = 0, n_err = 0;
  int unsigned ref_ph = 0;

  always #5 clk = ~clk;

  // reference tick: one cycle in three
  always @(negedge clk) begin
    ref_ph   <= (ref_ph == 2) ? 0 : ref_ph + 1;
    ref_tick <= (ref_ph == 1);
  end

  pwm_timebase dut (
    .clk(clk), .rst(rst), .fast_tick_i(fast_tick), .ref_tick_i(ref_tick),
    .src_sel_i(src_sel), .pause_i(pause), .clear_i(clear), .upd_load_i(load),
    .ratio_i(ratio), .res_i(res), .cnt_o(cnt), .wrap_o(wrap),
    .upd_pending_o(pending)
  );

  // {sel, ratio, res, expected wrap interval in cycles}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 18'h00100, 5'd3, 24'd8},     // R3 plain ratio 1
    {1'b1, 18'h00300, 5'd2, 24'd12},    // R3 integer 3
    {1'b1, 18'h00000, 5'd2, 24'd4},     // R3 integer 0 acts as 1
    {1'b1, 18'h00280, 5'd1, 24'd5},     // R4 2.5
    {1'b1, 18'h00140, 5'd2, 24'd5},     // R4 1.25
    {1'b1, 18'h00225, 5'd8, 24'd549},   // R4 2+37/256
    {1'b0, 18'h00100, 5'd2, 24'd12},    // R2 reference source
    {1'b0, 18'h00200, 5'd0, 24'd6},     // R2 R5 res 0 on reference
    {1'b1, 18'h00100, 5'd0, 24'd1},     // R5 res 0 wraps every tick
    {1'b1, 18'h005FF, 5'd8, 24'd1535}   // R4 5+255/256
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic s, input logic [17:0] r, input logic [4:0] rs);
    @(negedge clk);
    clear = 1'b1; load = 1'b1; src_sel = s; ratio = r; res = rs;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic measure(output int iv);
    do @(negedge clk); while (!wrap);
    iv = 0;
    do begin @(negedge clk); iv++; end while (!wrap);
  endtask

  initial begin
    #1_500_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int iv, held, prev, nw;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 wrap", int'(wrap), 0);
    chk("R1 pending", int'(pending), 0);
    measure(iv);
    chk("R1 default interval", iv, 256);

    // vector table
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][47], VEC[i][46:29], VEC[i][28:24]);
      measure(iv);
      chk($sformatf("R2/R3/R4/R5 vector %0d interval", i), iv, int'(VEC[i][23:0]));
    end

    // R5 R3 linear stepping from clear
    setup(1'b1, 18'h00100, 5'd20);
    repeat (10) @(negedge clk);
    chk("R5 count after 10 cycles", int'(cnt), 9);

    // R6 clamp: res 31 behaves as 20, no early wrap
    setup(1'b1, 18'h00100, 5'd31);
    nw = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk);
      if (wrap) nw++;
    end
    chk("R6 count", int'(cnt), 69999);
    chk("R6 no wrap", nw, 0);

    // R7 pause
    setup(1'b1, 18'h00100, 5'd20);
    repeat (10) @(negedge clk);
    pause = 1'b1;
    @(negedge clk);
    held = int'(cnt);
    repeat (20) @(negedge clk);
    chk("R7 frozen", int'(cnt), held);
    pause = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 resume", int'(cnt), held + 5);

    // R8 clear overrides pause
    pause = 1'b1; clear = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 cleared", int'(cnt), 0);
    chk("R8 no wrap", int'(wrap), 0);
    clear = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 stays 0 while paused", int'(cnt), 0);
    pause = 1'b0;

    // R10 R9 shadow update waits for the wrap
    setup(1'b1, 18'h00100, 5'd4);
    do @(negedge clk); while (cnt != 20'd3);
    load = 1'b1; res = 5'd2;
    @(negedge clk);
    load = 1'b0;
    chk("R10 pending raised", int'(pending), 1);
    prev = int'(cnt);
    @(negedge clk);
    while (!wrap) begin prev = int'(cnt); @(negedge clk); end
    chk("R10 old range completed", prev, 15);
    chk("R9 zero at wrap", int'(cnt), 0);
    chk("R10 pending cleared at wrap", int'(pending), 0);
    @(negedge clk);
    chk("R9 single-cycle pulse", int'(wrap), 0);
    measure(iv);
    chk("R10 new range interval", iv, 4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule